// File: doc/BRIEF.md
# Four-Bank DRAM Command Spacing Tracker

This block sits between a memory controller's command scheduler and the command pins of a four-bank synchronous DRAM. Each cycle the scheduler offers one decoded command: activate, read, write, precharge, refresh or burst stop. The command carries a bank number and a multiplexed address. The tracker holds an open or closed flag for every bank, plus a set of saturating down-counters, one for each minimum spacing rule. In the same cycle it answers with either a grant (the command may go to the memory now) or a stall (hold the command and offer it again later). A stalled command leaves all internal state unchanged.

All time limits are given as nanosecond parameters together with the clock period. At elaboration each limit becomes a cycle count: the time is divided by the period and rounded up. Writes are single-beat, so write data lands in the cycle the write is granted. Reads burst for a parameterised number of beats. Address bit 10 on a read or write requests automatic precharge. A live input picks the short write-recovery setting. An error flag reports a bank that has been left open longer than the maximum row-open time.

The cycle counts in the requirements assume a 10 ns clock, 20 ns for the bank-to-bank, activate-to-column and precharge spacings, a 50 ns minimum open time, 20 ns extra write-to-activate time and a read burst of 4. The bench overrides only the same-bank activate cycle (90 ns, 9 cycles) and the maximum open time (1000 ns, 100 cycles).

Top module: `dram_timing_tracker`

## Requirements
- R1: Command codes on cmd_op are 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 burst stop. A granted activate opens bank cmd_bank from the next cycle (bank_open bit i is bank i). An activate to a bank that is already open is stalled.
- R2: Two activates to different banks are at least 2 cycles apart. An activate in the cycle right after another activate is stalled.
- R3: A read or write to a bank is granted no earlier than 2 cycles after that bank's activate. A read or write to a closed bank is stalled.
- R4: A precharge to an open bank is stalled until 5 cycles after its activate. Once granted, it closes the bank from the next cycle. An activate to that bank is stalled until 2 cycles after the precharge.
- R5: Two activates to the same bank are at least 9 cycles apart (bench setting), even when the precharge spacing would allow an earlier one.
- R6: A precharge after a write to the same bank waits 2 cycles when wr_short is 0 and 1 cycle when wr_short is 1.
- R7: A read or write with cmd_addr bit 10 set closes the bank from the next cycle. It is stalled until 5 cycles after the activate. A later activate to that bank waits 6 cycles after an auto-precharge read, and 4 cycles (wr_short 0) or 3 cycles (wr_short 1) after an auto-precharge write.
- R8: Once a bank's activate-to-column spacing has passed, reads and writes are granted on consecutive cycles in any mix. A burst stop is granted in the cycle right after a write.
- R9: Refresh is granted only when all banks are closed and each bank's precharge spacing has expired. After a refresh, an activate to any bank waits 9 cycles.
- R10: ras_overrun rises when a bank has stayed open for more than 100 cycles (bench setting) without a precharge. It falls in the cycle after that bank is precharged.
- R11: cmd_grant and cmd_stall are combinational in the offered cycle, and at most one of them is high. With cmd_valid low, or with code 0, neither is high and no state changes.
- R12: After reset all banks are closed, ras_overrun is low, and a refresh is granted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_bank | input | 2 | Target bank |
| cmd_addr | input | 12 | Multiplexed row/column address; bit 10 requests auto-precharge on read/write |
| wr_short | input | 1 | Selects the shorter write-recovery spacing |
| cmd_grant | output | 1 | Offered command issues this cycle |
| cmd_stall | output | 1 | Offered command must be held |
| bank_open | output | 4 | Open flag per bank |
| ras_overrun | output | 1 | Some bank has exceeded the maximum open time |

## Verification
Every counter gates an answer in the cycle the command is offered. A counter that is loaded wrongly or decremented wrongly therefore shows at the ports as a grant or stall one or more cycles off, at the exact boundary cycle of that rule. The bench offers each command both one cycle before and at its legal cycle. An open flag that is never set or never cleared shows on bank_open one cycle after the grant, and it also shows through stalls of later activates and refreshes. The age counter shows through ras_overrun, which is checked in the cycle before its threshold and in the cycle of it.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_BST  = 3'd6
    } cmd_e;

    // whole cycles covering a time, rounded up
    function automatic int ns2ck(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dtt_bank.sv
module dtt_bank #(
    parameter int CW      = 4,
    parameter int RCD_CK  = 2,
    parameter int RAS_CK  = 5,
    parameter int RC_CK   = 7,
    parameter int RP_CK   = 2,
    parameter int RDAP_CK = 6,
    parameter int WRL_CK  = 2,
    parameter int WRS_CK  = 1,
    parameter int DALL_CK = 4,
    parameter int DALS_CK = 3,
    parameter int AGE_MAX = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic rd_go,
    input  logic wr_go,
    input  logic pre_go,
    input  logic ref_go,
    input  logic ap,
    input  logic wr_short,
    output logic is_open,
    output logic act_ok,
    output logic col_ok,
    output logic ras_ok,
    output logic pre_ok,
    output logic idle_ok,
    output logic overrun
);

    localparam int AGE_W = $clog2(AGE_MAX + 2);

    // load value N-1 gives a spacing of N cycles
    localparam logic [CW-1:0] L_RCD  = CW'((RCD_CK  > 0) ? RCD_CK  - 1 : 0);
    localparam logic [CW-1:0] L_RAS  = CW'((RAS_CK  > 0) ? RAS_CK  - 1 : 0);
    localparam logic [CW-1:0] L_RC   = CW'((RC_CK   > 0) ? RC_CK   - 1 : 0);
    localparam logic [CW-1:0] L_RP   = CW'((RP_CK   > 0) ? RP_CK   - 1 : 0);
    localparam logic [CW-1:0] L_RDAP = CW'((RDAP_CK > 0) ? RDAP_CK - 1 : 0);
    localparam logic [CW-1:0] L_WRL  = CW'((WRL_CK  > 0) ? WRL_CK  - 1 : 0);
    localparam logic [CW-1:0] L_WRS  = CW'((WRS_CK  > 0) ? WRS_CK  - 1 : 0);
    localparam logic [CW-1:0] L_DALL = CW'((DALL_CK > 0) ? DALL_CK - 1 : 0);
    localparam logic [CW-1:0] L_DALS = CW'((DALS_CK > 0) ? DALS_CK - 1 : 0);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(AGE_MAX);

    typedef struct packed {
        logic             open;
        logic [CW-1:0]    rcd;
        logic [CW-1:0]    ras;
        logic [CW-1:0]    rc;
        logic [CW-1:0]    rp;
        logic [CW-1:0]    wr;
        logic [AGE_W-1:0] age;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
        return (a > b) ? a : b;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rcd = dec(st_q.rcd);
        st_d.ras = dec(st_q.ras);
        st_d.rc  = dec(st_q.rc);
        st_d.rp  = dec(st_q.rp);
        st_d.wr  = dec(st_q.wr);
        if (st_q.open && (st_q.age <= AGE_LIM)) begin
            st_d.age = st_q.age + 1'b1;
        end

        if (act_go) begin
            st_d.open = 1'b1;
            st_d.rcd  = L_RCD;
            st_d.ras  = L_RAS;
            st_d.rc   = L_RC;
            st_d.age  = AGE_W'(1);
        end

        if (rd_go && ap) begin
            st_d.open = 1'b0;
            st_d.rp   = mx(st_d.rp, L_RDAP);
        end

        if (wr_go) begin
            st_d.wr = mx(st_d.wr, wr_short ? L_WRS : L_WRL);
            if (ap) begin
                st_d.open = 1'b0;
                st_d.rp   = mx(st_d.rp, wr_short ? L_DALS : L_DALL);
            end
        end

        if (pre_go && st_q.open) begin
            st_d.open = 1'b0;
            st_d.rp   = mx(st_d.rp, L_RP);
        end

        if (ref_go) begin
            st_d.rc = mx(st_d.rc, L_RC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_open = st_q.open;
    assign act_ok  = !st_q.open && (st_q.rp == '0) && (st_q.rc == '0);
    assign col_ok  = st_q.open && (st_q.rcd == '0);
    assign ras_ok  = (st_q.ras == '0);
    assign pre_ok  = !st_q.open || ((st_q.ras == '0) && (st_q.wr == '0));
    assign idle_ok = !st_q.open && (st_q.rp == '0);
    assign overrun = st_q.open && (st_q.age > AGE_LIM);

endmodule

// File: rtl/dtt_global.sv
module dtt_global #(
    parameter int CW     = 4,
    parameter int RRD_CK = 2,
    parameter int CCD_CK = 1,
    parameter int CDL_CK = 1,
    parameter int BDL_CK = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic rd_go,
    input  logic wr_go,
    output logic rrd_ok,
    output logic col_ok,
    output logic bst_ok
);

    localparam int WCOL_CK = (CCD_CK > CDL_CK) ? CCD_CK : CDL_CK;
    localparam logic [CW-1:0] L_RRD  = CW'((RRD_CK  > 0) ? RRD_CK  - 1 : 0);
    localparam logic [CW-1:0] L_CCD  = CW'((CCD_CK  > 0) ? CCD_CK  - 1 : 0);
    localparam logic [CW-1:0] L_WCOL = CW'((WCOL_CK > 0) ? WCOL_CK - 1 : 0);
    localparam logic [CW-1:0] L_BDL  = CW'((BDL_CK  > 0) ? BDL_CK  - 1 : 0);

    typedef struct packed {
        logic [CW-1:0] rrd;
        logic [CW-1:0] col;
        logic [CW-1:0] bdl;
    } glob_st_t;

    glob_st_t st_d, st_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d.rrd = dec(st_q.rrd);
        st_d.col = dec(st_q.col);
        st_d.bdl = dec(st_q.bdl);
        if (act_go) begin
            st_d.rrd = L_RRD;
        end
        if (rd_go) begin
            st_d.col = L_CCD;
        end
        if (wr_go) begin
            st_d.col = L_WCOL;
            st_d.bdl = L_BDL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rrd_ok = (st_q.rrd == '0);
    assign col_ok = (st_q.col == '0);
    assign bst_ok = (st_q.bdl == '0);

endmodule

// File: rtl/dram_timing_tracker.sv
module dram_timing_tracker
    import dtt_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int T_RRD_NS     = 20,
    parameter int T_RCD_NS     = 20,
    parameter int T_RP_NS      = 20,
    parameter int T_RAS_MIN_NS = 50,
    parameter int T_RAS_MAX_NS = 100000,
    parameter int T_RC_NS      = 70,
    parameter int T_DAL_NS     = 20,
    parameter int WR_LONG_CK   = 2,
    parameter int WR_SHORT_CK  = 1,
    parameter int T_CCD_CK     = 1,
    parameter int T_CDL_CK     = 1,
    parameter int T_BDL_CK     = 1,
    parameter int BURST_LEN    = 4,
    parameter int BANK_BITS    = 2,
    parameter int ADDR_BITS    = 12,
    parameter int AP_BIT       = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [BANK_BITS-1:0]     cmd_bank,
    input  logic [ADDR_BITS-1:0]     cmd_addr,
    input  logic                     wr_short,
    output logic                     cmd_grant,
    output logic                     cmd_stall,
    output logic [2**BANK_BITS-1:0]  bank_open,
    output logic                     ras_overrun
);

    localparam int NUM_BANKS  = 2 ** BANK_BITS;
    localparam int RRD_CK     = ns2ck(T_RRD_NS, CLK_NS);
    localparam int RCD_CK     = ns2ck(T_RCD_NS, CLK_NS);
    localparam int RP_CK      = ns2ck(T_RP_NS, CLK_NS);
    localparam int RAS_CK     = ns2ck(T_RAS_MIN_NS, CLK_NS);
    localparam int RASMAX_CK  = ns2ck(T_RAS_MAX_NS, CLK_NS);
    localparam int RC_CK      = ns2ck(T_RC_NS, CLK_NS);
    localparam int DALL_CK    = WR_LONG_CK + ns2ck(T_DAL_NS, CLK_NS);
    localparam int DALS_CK    = WR_SHORT_CK + ns2ck(T_DAL_NS, CLK_NS);
    localparam int RDAP_CK    = BURST_LEN + RP_CK;
    localparam int MAX_CK     = imax(imax(imax(RRD_CK, RCD_CK), imax(RAS_CK, RC_CK)),
                                     imax(imax(DALL_CK, RDAP_CK),
                                          imax(imax(T_CCD_CK, T_CDL_CK), T_BDL_CK)));
    localparam int CW         = $clog2(MAX_CK + 1) + 1;

    typedef struct packed {
        cmd_e op;
        logic ap;
        logic active;
        logic ready;
    } dec_t;

    dec_t dc;

    logic [NUM_BANKS-1:0] bk_open, bk_act_ok, bk_col_ok, bk_ras_ok;
    logic [NUM_BANKS-1:0] bk_pre_ok, bk_idle_ok, bk_over;
    logic [NUM_BANKS-1:0] act_go, rd_go, wr_go, pre_go;
    logic                 g_rrd_ok, g_col_ok, g_bst_ok;
    logic                 any_act, any_rd, any_wr, ref_go;
    logic                 unused_addr;

    assign unused_addr = ^cmd_addr;

    always_comb begin
        dc.op     = cmd_e'(cmd_op);
        dc.ap     = cmd_addr[AP_BIT];
        dc.active = cmd_valid && (dc.op != CMD_IDLE);
        case (dc.op)
            CMD_ACT: dc.ready = bk_act_ok[cmd_bank] && g_rrd_ok;
            CMD_RD,
            CMD_WR:  dc.ready = bk_col_ok[cmd_bank] && g_col_ok &&
                                (!dc.ap || bk_ras_ok[cmd_bank]);
            CMD_PRE: dc.ready = bk_pre_ok[cmd_bank];
            CMD_REF: dc.ready = &bk_idle_ok;
            CMD_BST: dc.ready = g_bst_ok;
            default: dc.ready = 1'b0;
        endcase
    end

    assign cmd_grant = dc.active && dc.ready;
    assign cmd_stall = dc.active && !dc.ready;
    assign ref_go    = cmd_grant && (dc.op == CMD_REF);
    assign any_act   = |act_go;
    assign any_rd    = |rd_go;
    assign any_wr    = |wr_go;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic sel;
        assign sel       = cmd_grant && (cmd_bank == BANK_BITS'(i));
        assign act_go[i] = sel && (dc.op == CMD_ACT);
        assign rd_go[i]  = sel && (dc.op == CMD_RD);
        assign wr_go[i]  = sel && (dc.op == CMD_WR);
        assign pre_go[i] = sel && (dc.op == CMD_PRE);

        dtt_bank #(
            .CW      (CW),
            .RCD_CK  (RCD_CK),
            .RAS_CK  (RAS_CK),
            .RC_CK   (RC_CK),
            .RP_CK   (RP_CK),
            .RDAP_CK (RDAP_CK),
            .WRL_CK  (WR_LONG_CK),
            .WRS_CK  (WR_SHORT_CK),
            .DALL_CK (DALL_CK),
            .DALS_CK (DALS_CK),
            .AGE_MAX (RASMAX_CK)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_go   (act_go[i]),
            .rd_go    (rd_go[i]),
            .wr_go    (wr_go[i]),
            .pre_go   (pre_go[i]),
            .ref_go   (ref_go),
            .ap       (dc.ap),
            .wr_short (wr_short),
            .is_open  (bk_open[i]),
            .act_ok   (bk_act_ok[i]),
            .col_ok   (bk_col_ok[i]),
            .ras_ok   (bk_ras_ok[i]),
            .pre_ok   (bk_pre_ok[i]),
            .idle_ok  (bk_idle_ok[i]),
            .overrun  (bk_over[i])
        );
    end

    dtt_global #(
        .CW     (CW),
        .RRD_CK (RRD_CK),
        .CCD_CK (T_CCD_CK),
        .CDL_CK (T_CDL_CK),
        .BDL_CK (T_BDL_CK)
    ) i_global (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_go (any_act),
        .rd_go  (any_rd),
        .wr_go  (any_wr),
        .rrd_ok (g_rrd_ok),
        .col_ok (g_col_ok),
        .bst_ok (g_bst_ok)
    );

    assign bank_open   = bk_open;
    assign ras_overrun = |bk_over;

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
    parameter int RRD_CK    = 2,
    parameter int BANK_BITS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [2:0]              cmd_op,
    input logic [BANK_BITS-1:0]    cmd_bank,
    input logic                    cmd_grant,
    input logic                    cmd_stall,
    input logic [2**BANK_BITS-1:0] bank_open,
    input logic                    ras_overrun
);

    logic       seen_act;
    logic [7:0] since_act;
    logic       act_granted;

    assign act_granted = cmd_grant && (cmd_op == 3'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_act  <= 1'b0;
            since_act <= '0;
        end else if (act_granted) begin
            seen_act  <= 1'b1;
            since_act <= 8'd1;
        end else if (since_act != 8'hFF) begin
            since_act <= since_act + 8'd1;
        end
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_granted |=> bank_open[$past(cmd_bank)]); // R1

    AST_ACT_CLOSED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        act_granted |-> !bank_open[cmd_bank]); // R1

    AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_granted && seen_act) |-> (since_act >= 8'(RRD_CK))); // R2

    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && cmd_op == 3'd4) |=> !bank_open[$past(cmd_bank)]); // R4

    AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_grant && cmd_op == 3'd5) |-> (bank_open == '0)); // R9

    AST_OVERRUN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ras_overrun |-> (bank_open != '0)); // R10

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_grant && cmd_stall)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == 3'd0) |-> (!cmd_grant && !cmd_stall)); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !ras_overrun) |=> (bank_open == $past(bank_open))); // R11

endmodule

bind dram_timing_tracker dtt_checker #(
    .RRD_CK    (RRD_CK),
    .BANK_BITS (BANK_BITS)
) i_dtt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_grant   (cmd_grant),
    .cmd_stall   (cmd_stall),
    .bank_open   (bank_open),
    .ras_overrun (ras_overrun)
);

// File: tb/test_dram_timing_tracker.sv
module test_dram_timing_tracker;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] OP_IDLE = 3'd0, OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
                           OP_PRE = 3'd4, OP_REF = 3'd5, OP_BST = 3'd6;
    localparam int EXP_STALL = 0, EXP_GRANT = 1, EXP_ANY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_bank = '0;
    logic [11:0] cmd_addr = '0;
    logic        wr_short = 1'b0;
    logic        cmd_grant, cmd_stall, ras_overrun;
    logic [3:0]  bank_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_timing_tracker #(
        .CLK_NS       (CLK_PERIOD),
        .T_RC_NS      (90),
        .T_RAS_MAX_NS (1000)
    ) i_dram_timing_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_bank    (cmd_bank),
        .cmd_addr    (cmd_addr),
        .wr_short    (wr_short),
        .cmd_grant   (cmd_grant),
        .cmd_stall   (cmd_stall),
        .bank_open   (bank_open),
        .ras_overrun (ras_overrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // one cycle: drive at negedge, sample 1 time unit later, move to next negedge
    task automatic step(input logic [2:0] op, input int bank, input bit ap,
                        input int expect_code, input string tag);
        cmd_valid = (op != OP_IDLE);
        cmd_op    = op;
        cmd_bank  = bank[1:0];
        cmd_addr  = 12'h0A5 | (ap ? 12'h400 : 12'h000);
        #1;
        if (expect_code == EXP_GRANT)
            check(cmd_grant === 1'b1 && cmd_stall === 1'b0, tag, {cmd_grant, cmd_stall}, 2);
        else if (expect_code == EXP_STALL)
            check(cmd_grant === 1'b0 && cmd_stall === 1'b1, tag, {cmd_grant, cmd_stall}, 1);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(OP_IDLE, 0, 1'b0, EXP_ANY, "");
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = OP_IDLE;
        wr_short  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check(bank_open === 4'b0000, "R12 banks closed", bank_open, 0);
        check(ras_overrun === 1'b0, "R12 overrun low", ras_overrun, 0);
        check(cmd_grant === 1'b0 && cmd_stall === 1'b0, "R12 no answer", {cmd_grant, cmd_stall}, 0);
        @(negedge clk);
        step(OP_REF, 0, 1'b0, EXP_GRANT, "R12 refresh after reset");
    endtask

    task automatic t_open_and_rrd();
        do_reset();
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R1 act bank0");
        check(bank_open === 4'b0001, "R1 bank0 open", bank_open, 1);
        step(OP_ACT, 1, 1'b0, EXP_STALL, "R2 act bank1 one cycle later");
        step(OP_ACT, 1, 1'b0, EXP_GRANT, "R2 act bank1 two cycles later");
        check(bank_open === 4'b0011, "R1 banks0,1 open", bank_open, 3);
        idle(2);
        step(OP_ACT, 0, 1'b0, EXP_STALL, "R1 act to open bank");
    endtask

    task automatic t_rcd();
        do_reset();
        step(OP_ACT, 2, 1'b0, EXP_GRANT, "R3 act bank2");
        step(OP_RD, 2, 1'b0, EXP_STALL, "R3 read one cycle after act");
        step(OP_RD, 2, 1'b0, EXP_GRANT, "R3 read two cycles after act");
        step(OP_RD, 3, 1'b0, EXP_STALL, "R3 read closed bank");
        step(OP_WR, 3, 1'b0, EXP_STALL, "R3 write closed bank");
    endtask

    task automatic t_ras_rp();
        do_reset();
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R4 act");
        idle(3);
        step(OP_PRE, 0, 1'b0, EXP_STALL, "R4 pre at 4 cycles");
        step(OP_PRE, 0, 1'b0, EXP_GRANT, "R4 pre at 5 cycles");
        check(bank_open === 4'b0000, "R4 pre closes bank", bank_open, 0);
        do_reset();
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R4 act");
        idle(9);
        step(OP_PRE, 0, 1'b0, EXP_GRANT, "R4 late pre");
        step(OP_ACT, 0, 1'b0, EXP_STALL, "R4 act one cycle after pre");
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R4 act two cycles after pre");
    endtask

    task automatic t_rc();
        do_reset();
        step(OP_ACT, 1, 1'b0, EXP_GRANT, "R5 act");
        idle(4);
        step(OP_PRE, 1, 1'b0, EXP_GRANT, "R5 pre");
        step(OP_ACT, 1, 1'b0, EXP_STALL, "R5 act at 6");
        step(OP_ACT, 1, 1'b0, EXP_STALL, "R5 act at 7");
        step(OP_ACT, 1, 1'b0, EXP_STALL, "R5 act at 8");
        step(OP_ACT, 1, 1'b0, EXP_GRANT, "R5 act at 9");
    endtask

    task automatic t_wr_recovery(input bit short_sel);
        do_reset();
        wr_short = short_sel;
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R6 act");
        idle(5);
        step(OP_WR, 0, 1'b0, EXP_GRANT, "R6 write");
        if (short_sel) begin
            step(OP_PRE, 0, 1'b0, EXP_GRANT, "R6 short pre one cycle after write");
        end else begin
            step(OP_PRE, 0, 1'b0, EXP_STALL, "R6 long pre one cycle after write");
            step(OP_PRE, 0, 1'b0, EXP_GRANT, "R6 long pre two cycles after write");
        end
    endtask

    task automatic t_rd_autopre();
        do_reset();
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R7 act");
        step(OP_RD, 0, 1'b1, EXP_STALL, "R7 ap read at 1");
        step(OP_RD, 0, 1'b1, EXP_STALL, "R7 ap read at 2 held by open time");
        step(OP_RD, 0, 1'b0, EXP_GRANT, "R3 plain read at 3");
        step(OP_RD, 0, 1'b1, EXP_STALL, "R7 ap read at 4");
        step(OP_RD, 0, 1'b1, EXP_GRANT, "R7 ap read at 5");
        check(bank_open === 4'b0000, "R7 ap read closes bank", bank_open, 0);
        idle(4);
        step(OP_ACT, 0, 1'b0, EXP_STALL, "R7 act 5 after ap read");
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R7 act 6 after ap read");
    endtask

    task automatic t_wr_autopre(input bit short_sel);
        do_reset();
        wr_short = short_sel;
        step(OP_ACT, 2, 1'b0, EXP_GRANT, "R7 act");
        idle(5);
        step(OP_WR, 2, 1'b1, EXP_GRANT, "R7 ap write");
        check(bank_open === 4'b0000, "R7 ap write closes bank", bank_open, 0);
        step(OP_ACT, 2, 1'b0, EXP_STALL, "R7 act 1 after ap write");
        step(OP_ACT, 2, 1'b0, EXP_STALL, "R7 act 2 after ap write");
        if (short_sel) begin
            step(OP_ACT, 2, 1'b0, EXP_GRANT, "R7 short act 3 after ap write");
        end else begin
            step(OP_ACT, 2, 1'b0, EXP_STALL, "R7 long act 3 after ap write");
            step(OP_ACT, 2, 1'b0, EXP_GRANT, "R7 long act 4 after ap write");
        end
    endtask

    task automatic t_column_stream();
        do_reset();
        step(OP_ACT, 3, 1'b0, EXP_GRANT, "R8 act");
        idle(1);
        step(OP_WR, 3, 1'b0, EXP_GRANT, "R8 write");
        step(OP_RD, 3, 1'b0, EXP_GRANT, "R8 read after write");
        step(OP_WR, 3, 1'b0, EXP_GRANT, "R8 write after read");
        step(OP_BST, 3, 1'b0, EXP_GRANT, "R8 burst stop after write");
        step(OP_RD, 3, 1'b0, EXP_GRANT, "R8 read after stop");
    endtask

    task automatic t_refresh();
        do_reset();
        step(OP_REF, 0, 1'b0, EXP_GRANT, "R9 refresh idle");
        for (int k = 1; k < 9; k++) step(OP_ACT, 0, 1'b0, EXP_STALL, "R9 act during refresh");
        step(OP_ACT, 0, 1'b0, EXP_GRANT, "R9 act 9 after refresh");
        step(OP_REF, 0, 1'b0, EXP_STALL, "R9 refresh with open bank");
        idle(3);
        step(OP_PRE, 0, 1'b0, EXP_GRANT, "R9 pre");
        step(OP_REF, 0, 1'b0, EXP_STALL, "R9 refresh in precharge spacing");
        step(OP_REF, 0, 1'b0, EXP_GRANT, "R9 refresh after spacing");
    endtask

    task automatic t_overrun();
        do_reset();
        step(OP_ACT, 1, 1'b0, EXP_GRANT, "R10 act");
        idle(99);
        #1;
        check(ras_overrun === 1'b0, "R10 flag low at limit", ras_overrun, 0);
        #(CLK_PERIOD - 1);
        idle(1);
        #1;
        check(ras_overrun === 1'b1, "R10 flag high past limit", ras_overrun, 1);
        #(CLK_PERIOD - 1);
        step(OP_PRE, 1, 1'b0, EXP_GRANT, "R10 pre");
        #1;
        check(ras_overrun === 1'b0, "R10 flag cleared by pre", ras_overrun, 0);
        #(CLK_PERIOD - 1);
    endtask

    task automatic t_ignored();
        do_reset();
        cmd_valid = 1'b0;
        cmd_op    = OP_ACT;
        cmd_bank  = 2'd2;
        #1;
        check(cmd_grant === 1'b0 && cmd_stall === 1'b0, "R11 invalid no answer",
              {cmd_grant, cmd_stall}, 0);
        @(negedge clk);
        check(bank_open === 4'b0000, "R11 invalid act ignored", bank_open, 0);
        step(OP_IDLE, 0, 1'b0, EXP_ANY, "");
        check(bank_open === 4'b0000, "R11 idle code ignored", bank_open, 0);
        step(OP_ACT, 2, 1'b0, EXP_GRANT, "R11 act granted same cycle");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_open_and_rrd();
        t_rcd();
        t_ras_rp();
        t_rc();
        t_wr_recovery(1'b0);
        t_wr_recovery(1'b1);
        t_rd_autopre();
        t_wr_autopre(1'b0);
        t_wr_autopre(1'b1);
        t_column_stream();
        t_refresh();
        t_overrun();
        t_ignored();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule